// File: doc/BRIEF.md
# Two-Operand Arithmetic and Logic Unit with Double-Width Result

This block is a purely combinational arithmetic and logic unit. It takes two unsigned operands of `W` bits each and a 4-bit operation code, and it drives a result twice as wide as one operand. The operations are:

- addition, and subtraction in either direction;
- increment or decrement of either operand on its own;
- full-width unsigned multiplication;
- complement of either operand;
- the three bitwise logic operations;
- a magnitude comparison that reports exactly one of three outcomes.

The addition and subtraction paths use ripple chains. Each chain begins with a half adder at bit 0 and continues with full adders, and every full adder is two half adders whose carries are ORed. Subtraction has no carry-in. It reuses the same chain through the identity m − n = ~(~m + n), and the carry out of that sum is the borrow. The multiplier is an array of the same ripple chains, one row for each bit of the second operand.

The block has no clock and no state. A surrounding datapath presents operands and a code and reads the result in the same cycle, with the ALU's path depth counted in its timing budget. Because the result is a plain function of the current inputs, there is nothing to hold off and no back-pressure to manage.

Top module: `alu_core`

## Requirements
- R1: Code 0000 gives a + b. The carry out of bit W-1 appears at result bit W, and the bits above W are zero.
- R2: Code 0001 gives a − b as a two's-complement difference sign-extended from W+1 bits to 2W bits. With W=8, 0x00 − 0x01 gives 0xFFFF.
- R3: Code 0010 gives b − a, in the same sign-extended format as R2.
- R4: Code 0011 gives a + 1 and code 0100 gives b + 1. The carry appears at bit W, and the bits above W are zero.
- R5: Code 0101 gives a − 1 and code 0110 gives b − 1, sign-extended as in R2. A zero operand gives all ones.
- R6: Code 0111 gives the full 2W-bit unsigned product a · b.
- R7: Code 1000 gives ~a and code 1001 gives ~b in the low W bits, and the upper W bits are zero.
- R8: Code 1010 gives a AND b, code 1011 gives a OR b and code 1100 gives a XOR b, each in the low W bits with the upper W bits zero.
- R9: Code 1101 drives result bits [2:0] as {greater, less, equal}, comparing a with b unsigned. Exactly one of these bits is set and all other result bits are zero.
- R10: Codes 1110 and 1111 give an all-zero result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | W (8) | First unsigned operand |
| b | input | W (8) | Second unsigned operand |
| op | input | 4 | Operation code, as listed in the requirements |
| res | output | 2W (16) | Result of the selected operation |

## Verification
The bench builds the block with its default width, W=8. At that width the wrap points can all be reached directly: 0xFF+0xFF, 0x00−0xFF, 0xFF·0xFF and decrement of zero each go through the complete carry or borrow chain. Random operands at the same width cover all fourteen codes and the two unused codes, so every multiplier row and every comparator stage is driven with varied data.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUBA = 4'd1,
    OP_SUBB = 4'd2,
    OP_INCA = 4'd3,
    OP_INCB = 4'd4,
    OP_DECA = 4'd5,
    OP_DECB = 4'd6,
    OP_MUL  = 4'd7,
    OP_NOTA = 4'd8,
    OP_NOTB = 4'd9,
    OP_AND  = 4'd10,
    OP_OR   = 4'd11,
    OP_XOR  = 4'd12,
    OP_CMP  = 4'd13
  } alu_op_e;
endpackage

// File: rtl/alu_half_add.sv
module alu_half_add (
  input  logic x,
  input  logic y,
  output logic s,
  output logic c
);
  assign s = x ^ y;
  assign c = x & y;
endmodule

// File: rtl/alu_ripple_add.sv
// N-bit ripple adder: half adder at bit 0, full adders above it.
module alu_ripple_add #(
  parameter int N = 8
) (
  input  logic [N-1:0] x,
  input  logic [N-1:0] y,
  output logic [N-1:0] s,
  output logic         cout
);
  logic carry [0:N-1];

  alu_half_add u_bit0 (.x(x[0]), .y(y[0]), .s(s[0]), .c(carry[0]));

  for (genvar i = 1; i < N; i++) begin : g_fa
    logic p, g1, g2;
    alu_half_add u_h1 (.x(x[i]), .y(y[i]), .s(p), .c(g1));
    alu_half_add u_h2 (.x(p), .y(carry[i-1]), .s(s[i]), .c(g2));
    assign carry[i] = g1 | g2;
  end

  assign cout = carry[N-1];
endmodule

// File: rtl/alu_shift_mult.sv
// Array multiplier: one ripple row per bit of the second operand.
module alu_shift_mult #(
  parameter int W = 8
) (
  input  logic [W-1:0]   x,
  input  logic [W-1:0]   y,
  output logic [2*W-1:0] p
);
  localparam int PW = 2 * W;

  logic [W-1:0] hi [0:W-1];
  logic         co [0:W-1];

  assign hi[0] = x & {W{y[0]}};
  assign co[0] = 1'b0;

  for (genvar i = 1; i < W; i++) begin : g_row
    logic [W-1:0] pp;
    logic [W-1:0] carried;
    assign pp      = x & {W{y[i]}};
    assign carried = {co[i-1], hi[i-1][W-1:1]};
    alu_ripple_add #(.N(W)) u_row (
      .x(carried), .y(pp), .s(hi[i]), .cout(co[i])
    );
    assign p[i-1] = hi[i-1][0];
  end

  assign p[PW-1:W-1] = {co[W-1], hi[W-1]};
endmodule

// File: rtl/alu_mag_cmp.sv
// Unsigned magnitude compare, resolved from LSB upward.
module alu_mag_cmp #(
  parameter int W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic         eq,
  output logic         lt,
  output logic         gt
);
  logic lt_c [0:W-1];

  assign lt_c[0] = ~x[0] & y[0];
  for (genvar i = 1; i < W; i++) begin : g_stage
    assign lt_c[i] = (~x[i] & y[i]) | (~(x[i] ^ y[i]) & lt_c[i-1]);
  end

  assign eq = ~|(x ^ y);
  assign lt = lt_c[W-1];
  assign gt = ~lt & ~eq;
endmodule

// File: rtl/alu_core.sv
module alu_core #(
  parameter int W = 8
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic [3:0]     op,
  output logic [2*W-1:0] res
);
  import alu_pkg::*;

  localparam int RW = 2 * W;
  localparam logic [W-1:0] ONE = W'(1);

  alu_op_e opc;
  assign opc = alu_op_e'(op);

  // Sum path (add and increment)
  logic [W-1:0] add_x, add_y, add_s;
  logic         add_c;
  // Difference path: m - n computed as ~(~m + n)
  logic [W-1:0] sub_m, sub_n, sub_s, diff;
  logic         borrow;
  logic [RW-1:0] prod;
  logic cmp_eq, cmp_lt, cmp_gt;

  always_comb begin
    add_x = a;
    add_y = b;
    sub_m = a;
    sub_n = b;
    unique case (opc)
      OP_INCA: add_y = ONE;
      OP_INCB: begin add_x = b; add_y = ONE; end
      OP_SUBB: begin sub_m = b; sub_n = a; end
      OP_DECA: sub_n = ONE;
      OP_DECB: begin sub_m = b; sub_n = ONE; end
      default: ;
    endcase
  end

  alu_ripple_add #(.N(W)) u_sum (
    .x(add_x), .y(add_y), .s(add_s), .cout(add_c)
  );

  alu_ripple_add #(.N(W)) u_dif (
    .x(~sub_m), .y(sub_n), .s(sub_s), .cout(borrow)
  );
  assign diff = ~sub_s;

  alu_shift_mult #(.W(W)) u_mul (.x(a), .y(b), .p(prod));

  alu_mag_cmp #(.W(W)) u_cmp (
    .x(a), .y(b), .eq(cmp_eq), .lt(cmp_lt), .gt(cmp_gt)
  );

  always_comb begin
    res = '0;
    case (opc)
      OP_ADD, OP_INCA, OP_INCB:
        res = {{(W-1){1'b0}}, add_c, add_s};
      OP_SUBA, OP_SUBB, OP_DECA, OP_DECB:
        res = {{(W-1){borrow}}, borrow, diff};
      OP_MUL:  res = prod;
      OP_NOTA: res = {{W{1'b0}}, ~a};
      OP_NOTB: res = {{W{1'b0}}, ~b};
      OP_AND:  res = {{W{1'b0}}, a & b};
      OP_OR:   res = {{W{1'b0}}, a | b};
      OP_XOR:  res = {{W{1'b0}}, a ^ b};
      OP_CMP:  res = {{(RW-3){1'b0}}, cmp_gt, cmp_lt, cmp_eq};
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk #(
  parameter int W = 8
) (
  input logic [W-1:0]   a,
  input logic [W-1:0]   b,
  input logic [3:0]     op,
  input logic [2*W-1:0] res
);
  localparam int RW = 2 * W;

  always_comb begin
    if (op == 4'd0 || op == 4'd3 || op == 4'd4) begin
      // R1
      sum_upper_chk: assert (res[RW-1:W+1] == '0)
        else $error("sum path upper bits not zero");
    end
    if (op == 4'd1 || op == 4'd2 || op == 4'd5 || op == 4'd6) begin
      // R2
      diff_sext_chk: assert (res[RW-1:W] == '0 || res[RW-1:W] == '1)
        else $error("difference not sign-extended");
    end
    if (op == 4'd7) begin
      // R6
      mul_prod_chk: assert (res == ({{W{1'b0}}, a} * {{W{1'b0}}, b}))
        else $error("product mismatch");
    end
    if (op == 4'd8) begin
      // R7
      nota_chk: assert ((res[W-1:0] ^ a) == '1 && res[RW-1:W] == '0)
        else $error("complement of a wrong");
    end
    if (op >= 4'd10 && op <= 4'd12) begin
      // R8
      logic_upper_chk: assert (res[RW-1:W] == '0)
        else $error("logic op upper bits not zero");
    end
    if (op == 4'd13) begin
      // R9
      cmp_onehot_chk: assert ($onehot(res[2:0]) && res[RW-1:3] == '0
                              && (res[0] == (a == b)))
        else $error("compare encoding wrong");
    end
    if (op >= 4'd14) begin
      // R10
      unused_zero_chk: assert (res == '0)
        else $error("unused code gave nonzero result");
    end
  end
endmodule

bind alu_core alu_core_chk #(.W(W)) u_chk (
  .a(a), .b(b), .op(op), .res(res)
);

// File: tb/sim_alu_core.sv
module sim_alu_core;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0]   a = '0;
  logic [W-1:0]   b = '0;
  logic [3:0]     op = 4'd14;
  logic [2*W-1:0] res;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  alu_core #(.W(W)) u0 (.a(a), .b(b), .op(op), .res(res));

  function automatic logic [15:0] model(input logic [3:0] c,
                                        input logic [7:0] x,
                                        input logic [7:0] y);
    int ia = int'(x);
    int ib = int'(y);
    int r;
    case (c)
      4'd0:  r = ia + ib;
      4'd1:  r = ia - ib;
      4'd2:  r = ib - ia;
      4'd3:  r = ia + 1;
      4'd4:  r = ib + 1;
      4'd5:  r = ia - 1;
      4'd6:  r = ib - 1;
      4'd7:  r = ia * ib;
      4'd8:  r = 255 - ia;
      4'd9:  r = 255 - ib;
      4'd10: r = int'(x & y);
      4'd11: r = int'(x | y);
      4'd12: r = int'(x ^ y);
      4'd13: r = (ia == ib) ? 1 : ((ia < ib) ? 2 : 4);
      default: r = 0;
    endcase
    return r[15:0];
  endfunction

  function automatic string tag(input logic [3:0] c);
    case (c)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2: return "R3";
      4'd3, 4'd4: return "R4";
      4'd5, 4'd6: return "R5";
      4'd7: return "R6";
      4'd8, 4'd9: return "R7";
      4'd10, 4'd11, 4'd12: return "R8";
      4'd13: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic apply(input logic [3:0] c, input logic [7:0] x,
                       input logic [7:0] y);
    logic [15:0] exp;
    @(posedge clk);
    #1;
    op = c; a = x; b = y;
    @(negedge clk);
    exp = model(c, x, y);
    checks++;
    if (res !== exp) begin
      errors++;
      $display("FAIL %s op=%0d a=%02h b=%02h actual=%04h expected=%04h",
               tag(c), c, x, y, res, exp);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // Idle state with an unused code (R10)
    apply(4'd14, 8'hA5, 8'h3C);
    apply(4'd15, 8'hFF, 8'hFF);
    // R1 corners: carry into bit 8
    apply(4'd0, 8'hFF, 8'hFF);
    apply(4'd0, 8'h00, 8'h00);
    apply(4'd0, 8'h80, 8'h80);
    // R2 / R3: borrow and sign extension
    apply(4'd1, 8'h00, 8'h01);
    apply(4'd1, 8'h00, 8'hFF);
    apply(4'd1, 8'hFF, 8'h00);
    apply(4'd2, 8'h01, 8'h00);
    apply(4'd2, 8'h10, 8'h20);
    // R4 / R5: wrap points of increment and decrement
    apply(4'd3, 8'hFF, 8'h00);
    apply(4'd4, 8'h00, 8'hFF);
    apply(4'd5, 8'h00, 8'h55);
    apply(4'd6, 8'h55, 8'h00);
    apply(4'd6, 8'h55, 8'h80);
    // R6: product extremes
    apply(4'd7, 8'hFF, 8'hFF);
    apply(4'd7, 8'h00, 8'hC3);
    apply(4'd7, 8'h80, 8'h02);
    // R7 / R8
    apply(4'd8, 8'h0F, 8'hAA);
    apply(4'd9, 8'h0F, 8'hAA);
    apply(4'd10, 8'hF0, 8'h3C);
    apply(4'd11, 8'hF0, 8'h3C);
    apply(4'd12, 8'hF0, 8'h3C);
    // R9: each outcome plus MSB-only and LSB-only differences
    apply(4'd13, 8'h42, 8'h42);
    apply(4'd13, 8'h41, 8'h42);
    apply(4'd13, 8'h43, 8'h42);
    apply(4'd13, 8'h7F, 8'h80);
    apply(4'd13, 8'h80, 8'h7F);
    // Random sweep over all sixteen codes
    for (int n = 0; n < 4000; n++) begin
      apply(4'($urandom_range(0, 15)), 8'($urandom), 8'($urandom));
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule